// File: doc/BRIEF.md
# SD/MMC Host Register Front End

This block is the software-facing register window of a simple SD/MMC host controller. A processor reaches it through a plain 32-bit read/write port that decodes word offsets inside a 4 KiB window. Through that window software programs the data buffer address, the command argument, the block length and the block count. Writing a command word hands a one-cycle command pulse to a separate card responder. The responder later reports completion by returning four response words and a set of completion flags.

The completion flags gather in a small interrupt status register. A mask register selects which of them drive the single level interrupt line. Software clears flags one bit at a time by writing ones. Loading a new mask discards everything still pending. Length and count are stored one above the value software writes, so a written zero means one unit. A card-state word reports that a card is present, and it reports the write-protect level as read-only.

Top module: `mmc_host_regs`

## Requirements
- R1: After reset every register is zero. The interrupt, command pulse and error outputs are low, and reads of status and response words return zero.
- R2: A write to offset 0x00 clears each status bit whose position is set in the written data and leaves the other bits unchanged. Status bit 0 means end of command, bit 1 end of data and bit 2 state change.
- R3: A write to offset 0x04 loads the low three data bits as the interrupt mask and clears every status bit in the same cycle.
- R4: A read of offset 0x00 returns the status bits ANDed with the mask, in bits 2:0, with zeros above.
- R5: The `irq` output is high exactly when status ANDed with mask is nonzero.
- R6: A write to offset 0x24 (length) or 0x28 (count) stores the written value plus one, modulo 2^32, and the stored value appears on `blkLen` / `blkCnt`.
- R7: A read of offset 0x2C returns bit 0 = 1 (card present), bit 1 = `wrProtect`, and zeros elsewhere.
- R8: A write to offset 0x0C raises `cmdStrobe` for the single cycle that follows the write. During that cycle `cmdCode` carries the written word and `cmdArg` carries the last word written to offset 0x10.
- R9: When `rspValid` is high, the four response words load from `rspData`, with word k taken from bits 32k+31:32k and read at offset 0x14+4k. The `rspFlags` bits are ORed into the status.
- R10: Flags set by the responder in the same cycle as a clearing write (to offset 0x00 or 0x04) are kept. Setting wins over clearing.
- R11: An access to an offset above 0x2C, or to one that is not word aligned, sets the sticky `accessErr` flag, and such a read returns zero. Reads of the defined offsets that are not readable (0x04 through 0x10, 0x24, 0x28) return zero and raise no error. Writes to the response and card-state offsets change nothing.
- R12: Writes to offset 0x08 and 0x10 appear on `bufAddr` and `cmdArg` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte offset in the register window |
| busWrEn | input | 1 | Write request this cycle |
| busRdEn | input | 1 | Read request this cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, zero when no read |
| wrProtect | input | 1 | Card write-protect level |
| rspValid | input | 1 | Responder completion this cycle |
| rspFlags | input | 3 | Status bits to set on completion |
| rspData | input | 128 | Four response words |
| irq | output | 1 | Level interrupt |
| cmdStrobe | output | 1 | One-cycle command start pulse |
| cmdCode | output | 32 | Last written command word |
| cmdArg | output | 32 | Command argument |
| bufAddr | output | 32 | Buffer address |
| blkLen | output | 32 | Block length (written value + 1) |
| blkCnt | output | 32 | Block count (written value + 1) |
| accessErr | output | 1 | Sticky undefined-offset flag |

## Verification
The responder's completion flags can arrive in the same cycle as a software write that clears status, either a write-one-to-clear to the status word or a mask reload. The bench provokes both cases by asserting `rspValid` in the write cycle. It then reads the status back and watches `irq`, and expects the newly set flags to survive. A randomized phase mixes completions with writes to every offset, and a behavioural model compares every output on every clock.

// File: rtl/mmc_host_pkg.sv
package mmc_host_pkg;
  localparam int STAT_W     = 3;
  localparam int RESP_N     = 4;
  localparam int RESP_IDX_W = (RESP_N > 1) ? $clog2(RESP_N) : 1;

  // word indices (byte offset / 4); software depends on these positions
  localparam int IDX_STAT  = 0;
  localparam int IDX_MASK  = 1;
  localparam int IDX_BUF   = 2;
  localparam int IDX_CMD   = 3;
  localparam int IDX_ARG   = 4;
  localparam int IDX_RESP0 = 5;
  localparam int IDX_LEN   = IDX_RESP0 + RESP_N;
  localparam int IDX_CNT   = IDX_LEN + 1;
  localparam int IDX_STATE = IDX_CNT + 1;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_STAT,
    RD_RESP,
    RD_STATE
  } rdSel_e;

  typedef struct packed {
    logic                  wrStat;
    logic                  wrMask;
    logic                  wrBuf;
    logic                  wrCmd;
    logic                  wrArg;
    logic                  wrLen;
    logic                  wrCnt;
    rdSel_e                rdSel;
    logic [RESP_IDX_W-1:0] respIdx;
  } regStrobe_t;
endpackage

// File: rtl/mmc_host_ctrl.sv
module mmc_host_ctrl
  import mmc_host_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStrobe_t        strb,
  output logic              accessErr
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] wordIdx;
  int               wordIdxInt;
  logic [RESP_N-1:0] respHitVec;
  logic             known;
  logic             badAccess;
  logic             errFlag;

  assign aligned    = (busAddr[1:0] == 2'b00);
  assign wordIdx    = busAddr[ADDR_W-1:2];
  assign wordIdxInt = int'(wordIdx);

  for (genvar i = 0; i < RESP_N; i++) begin : gRespHit
    assign respHitVec[i] = (wordIdxInt == IDX_RESP0 + i);
  end

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_ZERO;
    known        = 1'b1;
    for (int i = 0; i < RESP_N; i++) begin
      if (respHitVec[i]) strb.respIdx = RESP_IDX_W'(i);
    end
    if (!aligned) begin
      known = 1'b0;
    end else begin
      case (wordIdxInt)
        IDX_STAT: begin
          strb.wrStat = busWrEn;
          if (busRdEn) strb.rdSel = RD_STAT;
        end
        IDX_MASK:  strb.wrMask = busWrEn;
        IDX_BUF:   strb.wrBuf  = busWrEn;
        IDX_CMD:   strb.wrCmd  = busWrEn;
        IDX_ARG:   strb.wrArg  = busWrEn;
        IDX_LEN:   strb.wrLen  = busWrEn;
        IDX_CNT:   strb.wrCnt  = busWrEn;
        IDX_STATE: if (busRdEn) strb.rdSel = RD_STATE;
        default: begin
          if (|respHitVec) begin
            if (busRdEn) strb.rdSel = RD_RESP;
          end else begin
            known = 1'b0;
          end
        end
      endcase
    end
  end

  assign badAccess = (busWrEn | busRdEn) & ~known;

  always_ff @(posedge clk) begin
    if (!rstN)          errFlag <= 1'b0;
    else if (badAccess) errFlag <= 1'b1;
  end

  assign accessErr = errFlag;

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |=> accessErr);

  assert_bad_flags_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr[1:0] != 2'b00) |=> accessErr);
endmodule

// File: rtl/mmc_host_dp.sv
module mmc_host_dp
  import mmc_host_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  regStrobe_t               strb,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  input  logic                     wrProtect,
  input  logic                     rspValid,
  input  logic [STAT_W-1:0]        rspFlags,
  input  logic [RESP_N*DATA_W-1:0] rspData,
  output logic                     irq,
  output logic                     cmdStrobe,
  output logic [DATA_W-1:0]        cmdCode,
  output logic [DATA_W-1:0]        cmdArg,
  output logic [DATA_W-1:0]        bufAddr,
  output logic [DATA_W-1:0]        blkLen,
  output logic [DATA_W-1:0]        blkCnt
);
  logic [STAT_W-1:0] stat, statNext, mask;
  logic [DATA_W-1:0] respWord [RESP_N];
  logic              cmdPulse;
  logic [DATA_W-1:0] codeReg, argReg, bufReg, lenReg, cntReg;

  // clearing first, then the responder's flags, so a fresh event is never lost
  always_comb begin
    statNext = stat;
    if (strb.wrStat) statNext = statNext & ~busWdata[STAT_W-1:0];
    if (strb.wrMask) statNext = '0;
    if (rspValid)    statNext = statNext | rspFlags;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat     <= '0;
      mask     <= '0;
      cmdPulse <= 1'b0;
      codeReg  <= '0;
      argReg   <= '0;
      bufReg   <= '0;
      lenReg   <= '0;
      cntReg   <= '0;
    end else begin
      stat     <= statNext;
      cmdPulse <= strb.wrCmd;
      if (strb.wrMask) mask    <= busWdata[STAT_W-1:0];
      if (strb.wrCmd)  codeReg <= busWdata;
      if (strb.wrArg)  argReg  <= busWdata;
      if (strb.wrBuf)  bufReg  <= busWdata;
      if (strb.wrLen)  lenReg  <= busWdata + DATA_W'(1);
      if (strb.wrCnt)  cntReg  <= busWdata + DATA_W'(1);
    end
  end

  for (genvar i = 0; i < RESP_N; i++) begin : gResp
    always_ff @(posedge clk) begin
      if (!rstN)         respWord[i] <= '0;
      else if (rspValid) respWord[i] <= rspData[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_STAT:  busRdata = DATA_W'(stat & mask);
      RD_RESP:  busRdata = respWord[strb.respIdx];
      RD_STATE: busRdata = {{(DATA_W-2){1'b0}}, wrProtect, 1'b1};
      default:  busRdata = '0;
    endcase
  end

  assign irq       = |(stat & mask);
  assign cmdStrobe = cmdPulse;
  assign cmdCode   = codeReg;
  assign cmdArg    = argReg;
  assign bufAddr   = bufReg;
  assign blkLen    = lenReg;
  assign blkCnt    = cntReg;

  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStat && !rspValid) |=> ((stat & $past(busWdata[STAT_W-1:0])) == '0));

  assert_mask_wipe_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrMask && !rspValid) |=> (stat == '0 && !irq));

  assert_flags_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> ((stat & $past(rspFlags)) == $past(rspFlags)));

  assert_len_plus_one_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLen |=> (blkLen == $past(busWdata) + DATA_W'(1)));

  assert_strobe_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCmd |=> (cmdStrobe && cmdCode == $past(busWdata)));
endmodule

// File: rtl/mmc_host_regs.sv
module mmc_host_regs
  import mmc_host_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic                     busRdEn,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  input  logic                     wrProtect,
  input  logic                     rspValid,
  input  logic [STAT_W-1:0]        rspFlags,
  input  logic [RESP_N*DATA_W-1:0] rspData,
  output logic                     irq,
  output logic                     cmdStrobe,
  output logic [DATA_W-1:0]        cmdCode,
  output logic [DATA_W-1:0]        cmdArg,
  output logic [DATA_W-1:0]        bufAddr,
  output logic [DATA_W-1:0]        blkLen,
  output logic [DATA_W-1:0]        blkCnt,
  output logic                     accessErr
);
  regStrobe_t strb;

  mmc_host_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .strb      (strb),
    .accessErr (accessErr)
  );

  mmc_host_dp #(.DATA_W(DATA_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .wrProtect (wrProtect),
    .rspValid  (rspValid),
    .rspFlags  (rspFlags),
    .rspData   (rspData),
    .irq       (irq),
    .cmdStrobe (cmdStrobe),
    .cmdCode   (cmdCode),
    .cmdArg    (cmdArg),
    .bufAddr   (bufAddr),
    .blkLen    (blkLen),
    .blkCnt    (blkCnt)
  );
endmodule

// File: tb/tb_mmc_host_regs.sv
module tb_mmc_host_regs;
  logic         clk = 1'b0;
  logic         rstN;
  logic [11:0]  busAddr;
  logic         busWrEn, busRdEn;
  logic [31:0]  busWdata, busRdata;
  logic         wrProtect;
  logic         rspValid;
  logic [2:0]   rspFlags;
  logic [127:0] rspData;
  logic         irq, cmdStrobe, accessErr;
  logic [31:0]  cmdCode, cmdArg, bufAddr, blkLen, blkCnt;

  always #4 clk = ~clk;

  mmc_host_regs dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWdata(busWdata), .busRdata(busRdata),
    .wrProtect(wrProtect), .rspValid(rspValid), .rspFlags(rspFlags),
    .rspData(rspData), .irq(irq), .cmdStrobe(cmdStrobe), .cmdCode(cmdCode),
    .cmdArg(cmdArg), .bufAddr(bufAddr), .blkLen(blkLen), .blkCnt(blkCnt),
    .accessErr(accessErr)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference model state
  logic [2:0]  mStat, mMask;
  logic [31:0] mBuf, mArg, mLen, mCnt, mCode;
  logic [31:0] mResp [4];
  logic        mErr, mStrobe;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit isKnown(input logic [11:0] a);
    return (a[1:0] == 2'b00) && (a <= 12'h02C);
  endfunction

  function automatic logic [31:0] expRead(input bit rd, input logic [11:0] a);
    if (!rd) return 32'h0;
    case (a)
      12'h000: return {29'b0, mStat & mMask};
      12'h014: return mResp[0];
      12'h018: return mResp[1];
      12'h01C: return mResp[2];
      12'h020: return mResp[3];
      12'h02C: return {30'b0, wrProtect, 1'b1};
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelReset();
    mStat = '0; mMask = '0; mBuf = '0; mArg = '0; mLen = '0; mCnt = '0;
    mCode = '0; mErr = 1'b0; mStrobe = 1'b0;
    for (int i = 0; i < 4; i++) mResp[i] = '0;
  endtask

  // one cycle: drive at negedge, compare mid-cycle, advance model at posedge
  task automatic step(input bit wr, input bit rd, input logic [11:0] a,
                      input logic [31:0] d, input bit rv, input logic [2:0] rf,
                      input logic [127:0] rdat, input string tag);
    logic [2:0] ns;
    busWrEn = wr; busRdEn = rd; busAddr = a; busWdata = d;
    rspValid = rv; rspFlags = rf; rspData = rdat;
    #1;
    chk({tag, " read data"}, busRdata, expRead(rd, a));
    chk("R5 irq level", {31'b0, irq}, {31'b0, |(mStat & mMask)});
    chk("R8 command strobe", {31'b0, cmdStrobe}, {31'b0, mStrobe});
    chk("R8 command code", cmdCode, mCode);
    chk("R12 argument", cmdArg, mArg);
    chk("R12 buffer address", bufAddr, mBuf);
    chk("R6 block length", blkLen, mLen);
    chk("R6 block count", blkCnt, mCnt);
    chk("R11 access error", {31'b0, accessErr}, {31'b0, mErr});
    @(posedge clk);
    mStrobe = wr && (a == 12'h00C);
    if (mStrobe) mCode = d;
    ns = mStat;
    if (wr && a == 12'h000) ns = ns & ~d[2:0];
    if (wr && a == 12'h004) begin ns = '0; mMask = d[2:0]; end
    if (rv) ns = ns | rf;
    mStat = ns;
    if (wr && a == 12'h008) mBuf = d;
    if (wr && a == 12'h010) mArg = d;
    if (wr && a == 12'h024) mLen = d + 32'd1;
    if (wr && a == 12'h028) mCnt = d + 32'd1;
    if (rv) for (int i = 0; i < 4; i++) mResp[i] = rdat[32*i +: 32];
    if ((wr || rd) && !isKnown(a)) mErr = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 12'h0, 32'h0, 0, 3'b0, 128'h0, tag);
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(1, 0, a, d, 0, 3'b0, 128'h0, tag);
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    step(0, 1, a, 32'h0, 0, 3'b0, 128'h0, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrProtect = 1'b0;
    busAddr = '0; busWrEn = 0; busRdEn = 0; busWdata = '0;
    rspValid = 0; rspFlags = '0; rspData = '0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rd(12'h000, "R1 status after reset");
    rd(12'h014, "R1 response after reset");
    rd(12'h02C, "R7 state wp low");

    // R12 buffer and argument
    wr(12'h008, 32'h1000_0040, "R12");
    wr(12'h010, 32'hDEAD_BEEF, "R12");
    idle("R12");

    // R8 command pulse, back to back and isolated
    wr(12'h00C, 32'h0000_0011, "R8");
    idle("R8");
    wr(12'h00C, 32'h0000_0012, "R8");
    wr(12'h00C, 32'h0000_0019, "R8");
    idle("R8");

    // R6 plus one and wrap
    wr(12'h024, 32'h0000_01FF, "R6");
    wr(12'h028, 32'hFFFF_FFFF, "R6");
    idle("R6");

    // R3/R4/R9 mask then completion
    wr(12'h004, 32'h0000_0003, "R3");
    step(0, 0, 12'h0, 0, 1, 3'b111,
         128'h4444_4444_3333_3333_2222_2222_1111_1111, "R9 completion");
    rd(12'h000, "R4 masked status");
    for (int k = 0; k < 4; k++) rd(12'h014 + 12'(4*k), "R9 response word");

    // R2 write one to clear
    wr(12'h000, 32'h0000_0001, "R2");
    rd(12'h000, "R2 status after clear");
    wr(12'h000, 32'h0000_0006, "R2");
    rd(12'h000, "R2 status all cleared");

    // R3 mask write wipes status
    step(0, 0, 12'h0, 0, 1, 3'b101, 128'h0, "R9");
    wr(12'h004, 32'h0000_0007, "R3");
    rd(12'h000, "R3 status after mask load");

    // R10 set wins over clear
    step(1, 0, 12'h000, 32'h1, 1, 3'b001, 128'h0, "R10 w1c collision");
    rd(12'h000, "R10 status survives w1c");
    step(1, 0, 12'h004, 32'h7, 1, 3'b010, 128'h0, "R10 mask collision");
    rd(12'h000, "R10 status survives mask load");

    // R5 masked flags keep irq low
    wr(12'h004, 32'h0, "R5");
    step(0, 0, 12'h0, 0, 1, 3'b111, 128'h0, "R5 masked");
    idle("R5");

    // R7 write protect
    wrProtect = 1'b1;
    rd(12'h02C, "R7 state wp high");
    wrProtect = 1'b0;

    // R11 non-readable, read-only writes, undefined offsets
    rd(12'h008, "R11 non-readable offset");
    rd(12'h024, "R11 non-readable length");
    wr(12'h014, 32'hFFFF_FFFF, "R11 write to response");
    rd(12'h014, "R11 response unchanged");
    wr(12'h02C, 32'h0, "R11 write to state");
    rd(12'h030, "R11 undefined read");
    idle("R11");
    wr(12'h101, 32'h55, "R11 misaligned write");
    rd(12'h000, "R11 status after error");

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      a = 12'(($urandom % 13) * 4);
      if ($urandom % 20 == 0) a = 12'($urandom);
      step(($urandom % 2) == 1, ($urandom % 2) == 1 ? 1'b1 : 1'b0, a, $urandom,
           ($urandom % 4) == 0, 3'($urandom),
           {$urandom, $urandom, $urandom, $urandom}, "R10 mixed");
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule